// File: doc/BRIEF.md
# Two-Level Hierarchical Lookahead Adder

A purely combinational adder of width W that sums two operands and a carry-in, giving a W-bit sum and a carry-out. Each bit position first forms a propagate term (XOR of the operand bits) and a generate term (AND of the operand bits). These per-bit terms feed a row of first-level lookahead modules, each covering `N0` bits. Every first-level module computes its internal carries directly from the carry entering the module. It also produces a single group propagate bit and a single group generate bit.

One second-level lookahead module of radix `N1` takes the group signals. It works out the carry entering every first-level module at once, so no carry ripples from one group to the next. A small output stage forms the carry-out from the second-level group signals and the carry-in.

The width is `W = N0 * N1`. The two radices are independent parameters, so the levels may be equal (for example 8 by 8) or different (for example 16-bit groups under a 4-way top module).

Top module: `hla_adder`

## Requirements
- R1: For every input, `{cout_o, sum_o}` equals `a_i + b_i + cin_i`, evaluated as an unsigned (W+1)-bit value.
- R2: Bit i has propagate `a_i[i] ^ b_i[i]` and generate `a_i[i] & b_i[i]`. These two are never both 1, and sum bit i is propagate XOR the carry into bit i. With equal operands (all propagates 0) the sum is `(a_i << 1) | cin_i`.
- R3: When every bit propagates (`b_i == ~a_i`), the carry-in reaches every bit. With `cin_i = 0` the sum is all ones and `cout_o = 0`. With `cin_i = 1` the sum is zero and `cout_o = 1`.
- R4: A carry generated in the top bit of first-level module k enters bit 0 of module k+1. For `a_i = b_i = 1 << (k*N0 + N0 - 1)`, the sum is `1 << ((k+1)*N0)` and `cout_o = 0`.
- R5: The carry-out is the second-level group generate OR (group propagate AND carry-in). For `a_i = b_i = 1 << (W-1)`, `cout_o = 1` and the sum equals `cin_i`.
- R6: First-level module 0 receives the external carry-in, and module k receives carry k of the second-level module. With zero operands and `cin_i = 1`, the sum is 1 and `cout_o = 0`.
- R7: Inside every lookahead module, the carry at position i+1 equals `g[i] | (p[i] & c[i])`. The module's group signals satisfy `gg | (gp & cin)` = the carry leaving the module.
- R8: `N0` and `N1` may differ. R1 holds for the configurations 8x8 and 16x4 at 64 bits, and for small configurations 2x3 and 4x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N0*N1 | First operand |
| b_i | input | N0*N1 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N0*N1 | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
On every input change, the embedded checks test three things: the arithmetic identity on the adder's ports, the exclusion between propagate and generate, and that each flattened lookahead carry agrees with the bit-serial recurrence. They also check that group generate and propagate reproduce each module's outgoing carry, and that every first-level module receives the carry that the second level assigned to it.

The carry-in routing at the edges, full-width propagation, hand-over of a carry across every group boundary, and correct results for unequal radices are shown only by the bench's directed and swept scenarios. Those scenarios cover exhaustive sweeps at the small widths and corner values plus random vectors at 64 bits.

// File: rtl/hla_pkg.sv
package hla_pkg;
  // Group summary produced by one lookahead module
  typedef struct packed {
    logic prop;
    logic gen;
  } grp_sig_t;
endpackage

// File: rtl/hla_bit_pg.sv
module hla_bit_pg #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] sum_o
);
  genvar k;
  generate
    for (k = 0; k < WIDTH; k++) begin : g_bit
      assign prop_o[k] = a_i[k] ^ b_i[k];
      assign gen_o[k]  = a_i[k] & b_i[k];
      assign sum_o[k]  = prop_o[k] ^ carry_i[k];
    end
  endgenerate

  always_comb begin
    // R2
    pg_exclusive_chk: assert ((prop_o & gen_o) == '0)
      else $error("propagate and generate both set");
  end
endmodule

// File: rtl/hla_lookahead.sv
module hla_lookahead
  import hla_pkg::*;
#(
  parameter int RADIX = 8
) (
  input  logic [RADIX-1:0] prop_i,
  input  logic [RADIX-1:0] gen_i,
  input  logic             cin_i,
  output logic [RADIX-1:0] carry_o,
  output grp_sig_t         grp_o
);
  // Carries at positions 0..RADIX in flattened sum-of-products form
  logic [RADIX:0] c_flat;
  logic           gg_q;
  logic           gp_q;

  always_comb begin
    logic term;
    logic acc;
    for (int i = 0; i <= RADIX; i++) begin
      term = cin_i;
      for (int k = 0; k < i; k++) term = term & prop_i[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k < i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      c_flat[i] = acc;
    end
  end

  always_comb begin
    logic term;
    gp_q = &prop_i;
    gg_q = 1'b0;
    for (int j = 0; j < RADIX; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < RADIX; k++) term = term & prop_i[k];
      gg_q = gg_q | term;
    end
  end

  assign carry_o  = c_flat[RADIX-1:0];
  assign grp_o.prop = gp_q;
  assign grp_o.gen  = gg_q;

  always_comb begin
    for (int i = 0; i < RADIX; i++) begin
      // R7
      carry_recur_chk: assert (c_flat[i+1] == (gen_i[i] | (prop_i[i] & c_flat[i])))
        else $error("lookahead carry disagrees with recurrence at %0d", i);
    end
    // R7
    group_out_chk: assert ((gg_q | (gp_q & cin_i)) == c_flat[RADIX])
      else $error("group signals disagree with outgoing carry");
  end
endmodule

// File: rtl/hla_adder.sv
module hla_adder
  import hla_pkg::*;
#(
  parameter int N0 = 8,
  parameter int N1 = 8
) (
  input  logic [N0*N1-1:0] a_i,
  input  logic [N0*N1-1:0] b_i,
  input  logic             cin_i,
  output logic [N0*N1-1:0] sum_o,
  output logic             cout_o
);
  localparam int W = N0 * N1;

  logic [W-1:0]  prop_w;
  logic [W-1:0]  gen_w;
  logic [W-1:0]  carry_w;
  logic [N1-1:0] grp_carry;
  logic [N1-1:0] grp_p;
  logic [N1-1:0] grp_g;
  grp_sig_t      top_grp;

  hla_bit_pg #(.WIDTH(W)) pg_i (
    .a_i(a_i), .b_i(b_i), .carry_i(carry_w),
    .prop_o(prop_w), .gen_o(gen_w), .sum_o(sum_o)
  );

  genvar k;
  generate
    for (k = 0; k < N1; k++) begin : g_lvl0
      grp_sig_t grp_s;
      hla_lookahead #(.RADIX(N0)) la_i (
        .prop_i (prop_w[k*N0 +: N0]),
        .gen_i  (gen_w[k*N0 +: N0]),
        .cin_i  (grp_carry[k]),
        .carry_o(carry_w[k*N0 +: N0]),
        .grp_o  (grp_s)
      );
      assign grp_p[k] = grp_s.prop;
      assign grp_g[k] = grp_s.gen;
    end
  endgenerate

  hla_lookahead #(.RADIX(N1)) top_i (
    .prop_i (grp_p),
    .gen_i  (grp_g),
    .cin_i  (cin_i),
    .carry_o(grp_carry),
    .grp_o  (top_grp)
  );

  assign cout_o = top_grp.gen | (top_grp.prop & cin_i);

  always_comb begin
    // R1
    sum_identity_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
      else $error("sum identity broken");
    // R6
    cin_entry_chk: assert (carry_w[0] == cin_i)
      else $error("bit 0 carry is not cin");
    for (int m = 1; m < N1; m++) begin
      // R6
      grp_handover_chk: assert (carry_w[m*N0] ==
        (grp_g[m-1] | (grp_p[m-1] & carry_w[(m-1)*N0])))
        else $error("group %0d received wrong carry", m);
    end
  end
endmodule

// File: tb/hla_adder_tb_top.sv
module hla_adder_tb_top;
  logic clk;
  logic rst_n;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // 8x8 main instance
  logic [63:0] a8, b8, s8; logic c8, co8;
  hla_adder #(.N0(8), .N1(8)) dut_i (.a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8));
  // 16x4
  logic [63:0] a16, b16, s16; logic c16, co16;
  hla_adder #(.N0(16), .N1(4)) dut_16x4_i (.a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
  // 2x3 (6 bits)
  logic [5:0] a6, b6, s6; logic c6, co6;
  hla_adder #(.N0(2), .N1(3)) dut_2x3_i (.a_i(a6), .b_i(b6), .cin_i(c6), .sum_o(s6), .cout_o(co6));
  // 4x2 (8 bits)
  logic [7:0] a4, b4, s4; logic c4, co4;
  hla_adder #(.N0(4), .N1(2)) dut_4x2_i (.a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4));

  task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply to both 64-bit instances and compare with given expectation
  task automatic apply64(input string req, input logic [63:0] a, input logic [63:0] b,
                         input logic ci, input logic [64:0] exp);
    a8 = a; b8 = b; c8 = ci; a16 = a; b16 = b; c16 = ci;
    #1;
    check({req, " 8x8"},  {co8, s8},   exp);
    check({req, " 16x4"}, {co16, s16}, exp);
  endtask

  task automatic t_reset_state();
    apply64("R6 zero", 64'd0, 64'd0, 1'b0, 65'd0);
  endtask

  task automatic t_cin_only();
    // R6: cin enters bit 0 of group 0
    apply64("R6", 64'd0, 64'd0, 1'b1, 65'd1);
  endtask

  task automatic t_equal_ops();
    // R2: equal operands -> shift plus cin
    logic [63:0] v = 64'h5A3C_0F96_1234_8001;
    apply64("R2", v, v, 1'b1, {v, 1'b1});
    apply64("R2", v, v, 1'b0, {v, 1'b0});
  endtask

  task automatic t_full_prop();
    logic [63:0] v = 64'hA5A5_F00F_0123_4567;
    apply64("R3 cin0", v, ~v, 1'b0, {1'b0, {64{1'b1}}});
    apply64("R3 cin1", v, ~v, 1'b1, {1'b1, 64'd0});
  endtask

  task automatic t_boundaries();
    // R4: carry from top bit of each group into next group, both radices
    for (int k = 0; k < 7; k++) begin
      a8 = 64'd1 << (k*8 + 7); b8 = a8; c8 = 1'b0; #1;
      check("R4 8x8", {co8, s8}, {1'b0, 64'd1 << ((k+1)*8)});
    end
    for (int k = 0; k < 3; k++) begin
      a16 = 64'd1 << (k*16 + 15); b16 = a16; c16 = 1'b0; #1;
      check("R4 16x4", {co16, s16}, {1'b0, 64'd1 << ((k+1)*16)});
    end
  endtask

  task automatic t_msb_cout();
    apply64("R5 cin0", 64'd1 << 63, 64'd1 << 63, 1'b0, {1'b1, 64'd0});
    apply64("R5 cin1", 64'd1 << 63, 64'd1 << 63, 1'b1, {1'b1, 64'd1});
  endtask

  task automatic t_random64();
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic        ci = 1'($urandom);
      apply64("R1 R8 random", a, b, ci, {1'b0, a} + {1'b0, b} + 65'(ci));
    end
  endtask

  task automatic t_exhaustive_small();
    // R8: 2x3 exhaustive
    for (int v = 0; v < (1 << 13); v++) begin
      a6 = v[5:0]; b6 = v[11:6]; c6 = v[12]; #1;
      check("R8 2x3", 65'({co6, s6}), 65'({1'b0, a6} + {1'b0, b6} + 7'(c6)));
    end
    // R8: 4x2 exhaustive
    for (int v = 0; v < (1 << 17); v++) begin
      a4 = v[7:0]; b4 = v[15:8]; c4 = v[16]; #1;
      check("R8 4x2", 65'({co4, s4}), 65'({1'b0, a4} + {1'b0, b4} + 9'(c4)));
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0; a16 = '0; b16 = '0; c16 = 1'b0;
    a6 = '0; b6 = '0; c6 = 1'b0; a4 = '0; b4 = '0; c4 = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_cin_only();
    t_equal_ops();
    t_full_prop();
    t_boundaries();
    t_msb_cout();
    t_random64();
    t_exhaustive_small();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule